// File: doc/BRIEF.md
# Receive Descriptor Batch Sizer

This block sits in front of the local descriptor cache of a receive path whose rings each use one fixed buffer size. Software programs a buffer size per ring; the block checks that size against a granularity and a minimum/maximum window and flags any ring whose setting breaks the rules. When a packet arrives, the block takes its ring number and byte length and works out exactly how many fixed-size buffers the packet fills. That number goes to the descriptor fetch side as one batch request, so descriptors are fetched on demand in one go rather than one at a time.

The count is the packet length divided by the ring's buffer size, rounded up. A sequential divider produces it, and a power-of-two buffer size takes a one-cycle shift shortcut. If the count is larger than the number of descriptors the cache currently holds, the block raises a shortfall indication and keeps the request back until enough descriptors are present. The byte capacity that a batch of N descriptors covers is N times the ring's buffer size, which is always at least the packet length.

Packets enter on a valid/ready port: `pkt_ready` is high only while no packet is in flight, and a packet is taken on a cycle where `pkt_valid` and `pkt_ready` are both high. Requests leave on a valid/ready port: once `req_valid` is raised it stays high, and ring, count and error flag stay constant, until the cycle where `req_ready` is high. Configuration and status pins are plain signals.

Top module: `rxq_desc_batcher`

## Requirements
- R1: After reset every ring is flagged misconfigured (`ring_bad` all ones), `pkt_ready` is 1, and `req_valid` and `shortfall` are 0.
- R2: A configuration write whose size is a multiple of 32 and lies between 64 and 16384 inclusive stores the size for that ring and clears its `ring_bad` bit in the next cycle.
- R3: A configuration write whose size is not a multiple of 32 is rejected, and the ring's `ring_bad` bit is 1 in the next cycle.
- R4: A configuration write whose size is below 64 or above 16384 is rejected, and the ring's `ring_bad` bit is 1 in the next cycle.
- R5: For a packet on a good ring whose buffer size is not a power of two, the request carries the packet's ring and a count equal to the packet length divided by the buffer size, rounded up, with `req_bad` = 0.
- R6: For a packet on a good ring whose buffer size is a power of two, the count follows the same rounded-up rule.
- R7: A zero-length packet on a good ring produces a request with count 0.
- R8: A packet on a flagged ring produces a request with `req_bad` = 1 and count 0.
- R9: While the computed count exceeds `avail_cnt`, `shortfall` is 1 and `req_valid` is 0; the request is raised only after `avail_cnt` reaches the count.
- R10: A raised request holds `req_valid`, ring, count and `req_bad` stable until `req_ready` is high, and `pkt_ready` is 0 while a request is pending.
- R11: Each ring keeps its own buffer size and flag; a write to one ring changes neither the size nor the flag of any other ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Buffer size write strobe |
| cfg_ring | input | RING_W | Ring addressed by the write |
| cfg_size | input | SIZE_W | Buffer size in bytes |
| ring_bad | output | NRINGS | Per-ring misconfigured flag, bit i for ring i |
| pkt_valid | input | 1 | Packet descriptor valid |
| pkt_ready | output | 1 | Block can take a packet |
| pkt_ring | input | RING_W | Ring of the incoming packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| avail_cnt | input | CNT_W | Descriptors currently held in the local cache |
| req_valid | output | 1 | Batch request valid |
| req_ready | input | 1 | Fetch side takes the request |
| req_ring | output | RING_W | Ring of the request |
| req_count | output | CNT_W | Number of descriptors in the batch |
| req_bad | output | 1 | Packet was on a misconfigured ring |
| shortfall | output | 1 | Count exceeds cached descriptors; request held |

## Verification
The bench goes after rounding at exact multiples and one byte past them, where a floor division or an unconditional +1 gives a count one too small or one too large. It uses both non-power-of-two and power-of-two sizes, since a wrong shift amount or a mask that loses the remainder breaks only the shortcut path, and it uses the maximum 16-bit length, where a divider that drops the top bit returns a much too small count. Size writes just below the minimum, above the maximum and off the 32-byte grid must set the ring's flag, and a design that skipped a check would send a normal request for that ring. With a cache that is too small or back-pressure from the fetch side, a design that released early would raise `req_valid` with `shortfall` high, or let the count change while the request waits.

// File: rtl/rxq_batch_pkg.sv
package rxq_batch_pkg;
  localparam int unsigned DEF_NRINGS   = 4;
  localparam int unsigned DEF_LEN_W    = 16;
  localparam int unsigned DEF_GRAN     = 32;
  localparam int unsigned DEF_MIN_SIZE = 64;
  localparam int unsigned DEF_MAX_SIZE = 16384;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_HOLD = 2'd2,
    ST_OUT  = 2'd3
  } batch_state_t;
endpackage

// File: rtl/rxq_bufsz_regs.sv
module rxq_bufsz_regs #(
  parameter int unsigned NRINGS   = 4,
  parameter int unsigned SIZE_W   = 16,
  parameter int unsigned GRAN     = 32,
  parameter int unsigned MIN_SIZE = 64,
  parameter int unsigned MAX_SIZE = 16384,
  localparam int unsigned RING_W  = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RING_W-1:0] wr_ring,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [RING_W-1:0] rd_ring,
  output logic [SIZE_W-1:0] rd_size,
  output logic              rd_bad,
  output logic [NRINGS-1:0] bad_vec
);
  logic [SIZE_W-1:0] size_q [NRINGS];
  logic [NRINGS-1:0] bad_q;
  logic              size_ok;

  // Granularity and window checks on the written value
  always_comb begin
    size_ok = ((32'(wr_size) % GRAN) == 0) &&
              (32'(wr_size) >= MIN_SIZE) &&
              (32'(wr_size) <= MAX_SIZE);
  end

  for (genvar g = 0; g < NRINGS; g++) begin : g_ring
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        size_q[g] <= SIZE_W'(MIN_SIZE);
        bad_q[g]  <= 1'b1;
      end else if (wr_en && (32'(wr_ring) == g)) begin
        bad_q[g] <= !size_ok;
        if (size_ok) size_q[g] <= wr_size;
      end
    end
  end

  assign rd_size = size_q[rd_ring];
  assign rd_bad  = bad_q[rd_ring];
  assign bad_vec = bad_q;
endmodule

// File: rtl/rxq_ceil_div.sv
module rxq_ceil_div #(
  parameter int unsigned W = 16,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo
);
  logic [W-1:0]  dvs_q, shf_q, res_q;
  logic [W:0]    rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic          pow2;
  logic [SW-1:0] sh_amt;
  logic [W-1:0]  low_mask;
  logic [W:0]    trial, rem_nx;
  logic          fits;
  logic [W-1:0]  shf_nx;

  always_comb begin
    pow2     = $onehot(divisor);
    low_mask = divisor - 1'b1;
    sh_amt   = '0;
    for (int i = 0; i < W; i++) begin
      if (divisor[i]) sh_amt = SW'(i);
    end
    trial  = {rem_q[W-1:0], shf_q[W-1]};
    fits   = trial >= {1'b0, dvs_q};
    rem_nx = fits ? (trial - {1'b0, dvs_q}) : trial;
    shf_nx = {shf_q[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvs_q  <= '0;
      shf_q  <= '0;
      res_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && pow2) begin
        res_q  <= (dividend >> sh_amt) + W'(|(dividend & low_mask));
        done_q <= 1'b1;
      end else if (start) begin
        dvs_q  <= divisor;
        shf_q  <= dividend;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        shf_q <= shf_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= shf_nx + W'(|rem_nx);
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = res_q;
endmodule

// File: rtl/rxq_desc_batcher.sv
module rxq_desc_batcher
  import rxq_batch_pkg::*;
#(
  parameter int unsigned NRINGS   = DEF_NRINGS,
  parameter int unsigned LEN_W    = DEF_LEN_W,
  parameter int unsigned GRAN     = DEF_GRAN,
  parameter int unsigned MIN_SIZE = DEF_MIN_SIZE,
  parameter int unsigned MAX_SIZE = DEF_MAX_SIZE,
  localparam int unsigned RING_W  = (NRINGS > 1) ? $clog2(NRINGS) : 1,
  localparam int unsigned SIZE_W  = LEN_W,
  localparam int unsigned CNT_W   = LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RING_W-1:0] cfg_ring,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic [NRINGS-1:0] ring_bad,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [RING_W-1:0] pkt_ring,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [CNT_W-1:0]  avail_cnt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [RING_W-1:0] req_ring,
  output logic [CNT_W-1:0]  req_count,
  output logic              req_bad,
  output logic              shortfall
);
  batch_state_t      state_q;
  logic [RING_W-1:0] ring_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              bad_q;

  logic [SIZE_W-1:0] rd_size;
  logic              rd_bad;
  logic              accept, div_start, div_done;
  logic [LEN_W-1:0]  div_quo;

  rxq_bufsz_regs #(
    .NRINGS(NRINGS), .SIZE_W(SIZE_W), .GRAN(GRAN),
    .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_ring(cfg_ring), .wr_size(cfg_size),
    .rd_ring(pkt_ring), .rd_size(rd_size), .rd_bad(rd_bad),
    .bad_vec(ring_bad)
  );

  rxq_ceil_div #(.W(LEN_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(div_start), .dividend(pkt_len), .divisor(rd_size),
    .done(div_done), .quo(div_quo)
  );

  assign pkt_ready = (state_q == ST_IDLE);
  assign accept    = pkt_valid && pkt_ready;
  assign div_start = accept && !rd_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ring_q  <= '0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ring_q <= pkt_ring;
          bad_q  <= rd_bad;
          cnt_q  <= '0;
          state_q <= rd_bad ? ST_OUT : ST_DIV;
        end
        ST_DIV: if (div_done) begin
          cnt_q   <= CNT_W'(div_quo);
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (cnt_q <= avail_cnt) state_q <= ST_OUT;
        ST_OUT:  if (req_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == ST_OUT);
  assign req_ring  = ring_q;
  assign req_count = cnt_q;
  assign req_bad   = bad_q;
  assign shortfall = (state_q == ST_HOLD) && (cnt_q > avail_cnt);
endmodule

// File: rtl/rxq_desc_batcher_chk.sv
module rxq_desc_batcher_chk #(
  parameter int unsigned NRINGS   = 4,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned MIN_SIZE = 64,
  parameter int unsigned MAX_SIZE = 16384,
  parameter int unsigned GRAN     = 32,
  localparam int unsigned RING_W  = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [RING_W-1:0] cfg_ring,
  input logic [LEN_W-1:0]  cfg_size,
  input logic [NRINGS-1:0] ring_bad,
  input logic              pkt_ready,
  input logic [LEN_W-1:0]  avail_cnt,
  input logic              req_valid,
  input logic              req_ready,
  input logic [RING_W-1:0] req_ring,
  input logic [LEN_W-1:0]  req_count,
  input logic              req_bad,
  input logic              shortfall
);
  p_off_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && ((32'(cfg_size) % GRAN) != 0) |=> ring_bad[$past(cfg_ring)]);

  p_out_of_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && ((32'(cfg_size) < MIN_SIZE) || (32'(cfg_size) > MAX_SIZE))
    |=> ring_bad[$past(cfg_ring)]);

  p_bad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_bad |-> req_count == '0);

  p_short_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shortfall |-> !req_valid);

  p_release_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !req_bad |-> $past(avail_cnt) >= req_count);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_count) &&
                                $stable(req_ring) && $stable(req_bad));

  p_one_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !pkt_ready);
endmodule

bind rxq_desc_batcher rxq_desc_batcher_chk #(
  .NRINGS(NRINGS), .LEN_W(LEN_W), .MIN_SIZE(MIN_SIZE),
  .MAX_SIZE(MAX_SIZE), .GRAN(GRAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
  .cfg_size(cfg_size), .ring_bad(ring_bad), .pkt_ready(pkt_ready),
  .avail_cnt(avail_cnt), .req_valid(req_valid), .req_ready(req_ready),
  .req_ring(req_ring), .req_count(req_count), .req_bad(req_bad),
  .shortfall(shortfall)
);

// File: tb/rxq_desc_batcher_bench.sv
module rxq_desc_batcher_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ring = '0;
  logic [15:0] cfg_size = '0;
  logic [3:0]  ring_bad;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [1:0]  pkt_ring = '0;
  logic [15:0] pkt_len = '0;
  logic [15:0] avail_cnt = 16'hFFFF;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [1:0]  req_ring;
  logic [15:0] req_count;
  logic        req_bad;
  logic        shortfall;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_desc_batcher u_rxq_desc_batcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
    .cfg_size(cfg_size), .ring_bad(ring_bad), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_ring(pkt_ring), .pkt_len(pkt_len),
    .avail_cnt(avail_cnt), .req_valid(req_valid), .req_ready(req_ready),
    .req_ring(req_ring), .req_count(req_count), .req_bad(req_bad),
    .shortfall(shortfall)
  );

  // Ring sizes used by the table: 96 and 1504 are not powers of two
  localparam int SIZES [4] = '{96, 64, 2048, 1504};
  // {ring, length}
  localparam logic [17:0] VEC [12] = '{
    {2'd0, 16'd1},    {2'd0, 16'd96},   {2'd0, 16'd97},   {2'd0, 16'd65535},
    {2'd1, 16'd64},   {2'd1, 16'd65},   {2'd1, 16'd65535}, {2'd2, 16'd2048},
    {2'd2, 16'd2049}, {2'd3, 16'd1500}, {2'd3, 16'd1505},  {2'd3, 16'd65535}
  };

  function automatic int ceil_div(int len, int sz);
    return (len + sz - 1) / sz;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int ring, int sz);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ring = 2'(ring); cfg_size = 16'(sz);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_pkt(int ring, int len);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_ring = 2'(ring); pkt_len = 16'(len);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // Waits for the request, checks it, then hands it over
  task automatic take_req(string tag, int ring, int cnt, bit isbad);
    int n = 0;
    while (!req_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req_valid, tag, int'(req_valid), 1);
    check(req_count == 16'(cnt), tag, int'(req_count), cnt);
    check(req_ring == 2'(ring), tag, int'(req_ring), ring);
    check(req_bad == isbad, tag, int'(req_bad), int'(isbad));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ring_bad == 4'hF, "R1 ring_bad", int'(ring_bad), 15);
    check(pkt_ready == 1'b1, "R1 pkt_ready", int'(pkt_ready), 1);
    check(!req_valid && !shortfall, "R1 req/short", int'(req_valid), 0);
    rst_n = 1'b1;

    // R8 packet on a ring never configured
    send_pkt(2, 500);
    take_req("R8 unconfigured", 2, 0, 1'b1);

    // R2 valid sizes on all rings
    for (int r = 0; r < 4; r++) write_cfg(r, SIZES[r]);
    check(ring_bad == 4'h0, "R2 flags cleared", int'(ring_bad), 0);

    // R5 / R6 / R11 table
    for (int i = 0; i < 12; i++) begin
      int rg = int'(VEC[i][17:16]);
      int ln = int'(VEC[i][15:0]);
      send_pkt(rg, ln);
      if (SIZES[rg] == 64 || SIZES[rg] == 2048)
        take_req("R6 pow2 count", rg, ceil_div(ln, SIZES[rg]), 1'b0);
      else
        take_req("R5 ceil count", rg, ceil_div(ln, SIZES[rg]), 1'b0);
    end

    // R7 zero length, both divider paths
    send_pkt(0, 0);
    take_req("R7 zero len div", 0, 0, 1'b0);
    send_pkt(1, 0);
    take_req("R7 zero len shift", 1, 0, 1'b0);

    // R9 shortfall: 300 bytes at 96 -> 4 descriptors, only 2 cached
    avail_cnt = 16'd2;
    send_pkt(0, 300);
    repeat (30) @(negedge clk);
    check(shortfall == 1'b1, "R9 shortfall high", int'(shortfall), 1);
    check(req_valid == 1'b0, "R9 request held", int'(req_valid), 0);
    avail_cnt = 16'd3;
    repeat (3) @(negedge clk);
    check(shortfall && !req_valid, "R9 still short at 3", int'(req_valid), 0);
    avail_cnt = 16'd4;
    @(negedge clk);
    @(negedge clk);
    check(req_valid && !shortfall, "R9 released", int'(req_valid), 1);
    avail_cnt = 16'hFFFF;
    take_req("R9 count", 0, 4, 1'b0);

    // R10 back-pressure
    send_pkt(3, 4000);
    repeat (30) @(negedge clk);
    check(req_valid == 1'b1, "R10 valid", int'(req_valid), 1);
    avail_cnt = 16'd0;
    repeat (5) @(negedge clk);
    check(req_valid && req_count == 16'd3, "R10 stable count", int'(req_count), 3);
    check(pkt_ready == 1'b0, "R10 pkt_ready low", int'(pkt_ready), 0);
    avail_cnt = 16'hFFFF;
    take_req("R10 handover", 3, 3, 1'b0);
    check(pkt_ready == 1'b1, "R10 pkt_ready back", int'(pkt_ready), 1);

    // R3 off-grid size on ring 3
    write_cfg(3, 100);
    check(ring_bad == 4'b1000, "R3 off grid", int'(ring_bad), 8);
    send_pkt(3, 200);
    take_req("R3 bad request", 3, 0, 1'b1);
    // R11 other rings unaffected
    send_pkt(0, 193);
    take_req("R11 ring0 intact", 0, 3, 1'b0);

    // R4 window bounds
    write_cfg(3, 16384);
    check(ring_bad == 4'b0000, "R4 max accepted", int'(ring_bad), 0);
    send_pkt(3, 16385);
    take_req("R4 max size count", 3, 2, 1'b0);
    write_cfg(3, 32);
    check(ring_bad[3] == 1'b1, "R4 below min", int'(ring_bad[3]), 1);
    write_cfg(3, 64);
    check(ring_bad[3] == 1'b0, "R4 min accepted", int'(ring_bad[3]), 0);
    write_cfg(3, 16416);
    check(ring_bad[3] == 1'b1, "R4 above max", int'(ring_bad[3]), 1);
    write_cfg(1, 70);
    check(ring_bad == 4'b1010, "R11 per-ring flags", int'(ring_bad), 10);
    send_pkt(1, 64);
    take_req("R8 rejected ring", 1, 0, 1'b1);
    send_pkt(2, 4097);
    take_req("R11 ring2 intact", 2, 3, 1'b0);

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule